// File: doc/BRIEF.md
# Tagless Data Address Stride Compressor

This block shrinks the data-address trace produced by load and store instructions. Each incoming record pairs the instruction's PC with the data address it touched. A direct-indexed table with no tags is addressed by a few PC bits. Each entry keeps the last data address and a narrow last stride seen at that slot. The block subtracts the stored address from the new one. If the difference matches the stored stride, the access is predicted and costs one `1` bit in the bit trace. Otherwise the block writes a `0` bit and sends the complete address out on a separate miss channel.

Records enter through a valid/ready pair. The block holds ready low while it processes a record: one extra cycle when the prediction holds, two when the entry's stride has to be rewritten. The producer side is expected to hold a small queue of records. Outcome bits are packed into bytes, first bit in the most significant position. A flush strobe pushes out a partly filled byte together with its bit count.

Top module: `stride_compressor`

## Requirements
- R1: The entry used for a record is selected by PC bits [IDX_W+1:2] alone (bits [11:2] by default) and no tag is compared, so two PCs that agree in those bits share one entry.
- R2: When the new address minus the entry's last address equals the entry's stored stride, the record yields a `1` bit and no miss record.
- R3: When the two differ, the record yields a `0` bit and exactly one miss record: `missValid` high for one cycle with `missAddr` equal to the full incoming address.
- R4: On a mismatch the stored stride becomes the low STRIDE_W (8) bits of the new stride. The comparison sign-extends the stored value, so a negative stride of -8 stored as 0xF8 predicts correctly, while any stride outside -128..127 can never match.
- R5: Every record, hit or miss, replaces the entry's last address with the incoming address.
- R6: After reset `inReady` is high, `traceValid` and `missValid` are low, and every entry reads as last address 0 and stride 0, so a first access to address 0 at any entry counts as a hit.
- R7: After a record is accepted, `inReady` stays low for one cycle if the prediction held and for two cycles if it failed.
- R8: Outcome bits fill a byte starting at bit 7. When the eighth bit arrives, `traceValid` pulses with `traceFill` = 8.
- R9: A flush with k pending bits (1..7) emits one byte holding those bits in its top k positions, zeros below them, and `traceFill` = k. A flush with no pending bits emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A (PC, address) record is offered |
| inReady | output | 1 | The block accepts a record in this cycle |
| inPc | input | PC_W | PC of the memory instruction |
| inAddr | input | ADDR_W | Data address of the access |
| flush | input | 1 | Push out any partly filled trace byte |
| traceValid | output | 1 | One-cycle strobe: `traceByte` is valid |
| traceByte | output | BYTE_W | Packed outcome bits, first bit at the MSB |
| traceFill | output | $clog2(BYTE_W+1) | Number of meaningful bits in `traceByte` |
| missValid | output | 1 | One-cycle strobe: `missAddr` is valid |
| missAddr | output | ADDR_W | Full address of a mispredicted access |

## Verification
On every cycle the assertions check the handshake stall after an accept, the fixed order of the lookup and stride-rewrite steps, that a miss record appears only after a failed comparison, and the limits of the packer's bit count and fill field. Only the bench's scenarios can show the arithmetic content: which records hit after aliasing, negative strides and truncation, the exact miss addresses, and the bit order and padding inside packed and flushed bytes. The stall length per outcome is also measured there at the ports.

// File: rtl/stride_comp_pkg.sv
package stride_comp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FIXUP  = 2'd2
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;      // latch record, start table read
    logic judge;        // compare, emit bit and miss record, write last address
    logic writeAddr;    // table entry write (address plus kept stride)
    logic writeStride;  // table stride rewrite after a mismatch
  } ctrlStrobes_t;

endpackage

// File: rtl/stride_table.sv
module stride_table #(
  parameter int IDX_W    = 10,
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rdEn,
  input  logic [IDX_W-1:0]    rdIdx,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic                wrAddrEn,
  input  logic [ADDR_W-1:0]   wrAddrData,
  input  logic                wrStrideEn,
  input  logic [STRIDE_W-1:0] wrStrideData,
  output logic [ADDR_W-1:0]   rdLastAddr,
  output logic [STRIDE_W-1:0] rdStride
);

  localparam int DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0]   lastMem   [DEPTH];
  logic [STRIDE_W-1:0] strideMem [DEPTH];
  logic [DEPTH-1:0]    written;

  // Storage arrays carry no reset; the written vector masks stale content.
  always_ff @(posedge clk) begin
    if (wrAddrEn) lastMem[wrIdx] <= wrAddrData;
    if (wrAddrEn || wrStrideEn) strideMem[wrIdx] <= wrStrideData;
  end

  always_ff @(posedge clk) begin
    if (rst) written <= '0;
    else if (wrAddrEn) written[wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdLastAddr <= '0;
      rdStride   <= '0;
    end else if (rdEn) begin
      rdLastAddr <= written[rdIdx] ? lastMem[rdIdx]   : '0;
      rdStride   <= written[rdIdx] ? strideMem[rdIdx] : '0;
    end
  end

endmodule

// File: rtl/trace_packer.sv
module trace_packer #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitValid,
  input  logic              bitVal,
  input  logic              flush,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic [CNT_W-1:0]  byteFill
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic [BYTE_W-1:0] shReg, nextReg, aligned;
  logic [CNT_W-1:0]  cntQ, nextCnt;
  logic              push;

  always_comb begin
    nextReg = bitValid ? {shReg[BYTE_W-2:0], bitVal} : shReg;
    nextCnt = cntQ + {{(CNT_W-1){1'b0}}, bitValid};
    push    = (nextCnt == FULL_CNT) || (flush && (nextCnt != '0));
    aligned = nextReg << (FULL_CNT - nextCnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg     <= '0;
      cntQ      <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteFill  <= '0;
    end else begin
      byteValid <= push;
      if (push) begin
        byteData <= aligned;
        byteFill <= nextCnt;
        shReg    <= '0;
        cntQ     <= '0;
      end else begin
        shReg <= nextReg;
        cntQ  <= nextCnt;
      end
    end
  end

  // R8: the pending count never reaches a full byte
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cntQ < FULL_CNT);

  // R8: a byte pushed without a flush request is a full one
  assert_full_byte_R8: assert property (@(posedge clk) disable iff (rst)
    (byteValid && !$past(flush)) |-> byteFill == FULL_CNT);

  // R9: every emitted byte carries between one and BYTE_W bits
  assert_fill_range_R9: assert property (@(posedge clk) disable iff (rst)
    byteValid |-> (byteFill != '0) && (byteFill <= FULL_CNT));

endmodule

// File: rtl/stride_control.sv
module stride_control
  import stride_comp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         strideHit,
  output logic         inReady,
  output ctrlStrobes_t strobes
);

  ctrlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    strobes   = '0;
    nextState = state;
    inReady   = 1'b0;
    case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          strobes.capture = 1'b1;
          nextState       = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        strobes.judge     = 1'b1;
        strobes.writeAddr = 1'b1;
        nextState         = strideHit ? ST_IDLE : ST_FIXUP;
      end
      ST_FIXUP: begin
        strobes.writeStride = 1'b1;
        nextState           = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R7: an accepted record always stalls the next cycle
  assert_accept_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);

  // R7: the stride rewrite step only follows a failed comparison
  assert_fixup_after_miss_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.writeStride |-> ($past(strobes.judge) && !$past(strideHit)));

  // R7: the three phases never overlap
  assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.capture, strobes.judge, strobes.writeStride}));

endmodule

// File: rtl/stride_datapath.sv
module stride_datapath
  import stride_comp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 10,
  parameter int STRIDE_W = 8,
  parameter int BYTE_W   = 8,
  localparam int FILL_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [PC_W-1:0]   inPc,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              flush,
  output logic              strideHit,
  output logic              traceValid,
  output logic [BYTE_W-1:0] traceByte,
  output logic [FILL_W-1:0] traceFill,
  output logic              missValid,
  output logic [ADDR_W-1:0] missAddr
);

  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = IDX_W + IDX_LSB - 1;
  localparam int EXT_W   = ADDR_W - STRIDE_W;

  logic [IDX_W-1:0]    rdIdx, idxQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [ADDR_W-1:0]   rdLastAddr;
  logic [STRIDE_W-1:0] rdStride, wrStrideData;
  logic [ADDR_W-1:0]   curStride, predStride;
  logic                unusedPcBits;

  assign rdIdx        = inPc[IDX_MSB:IDX_LSB];
  assign unusedPcBits = ^{inPc[PC_W-1:IDX_MSB+1], inPc[IDX_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ  <= '0;
      addrQ <= '0;
    end else if (strobes.capture) begin
      idxQ  <= rdIdx;
      addrQ <= inAddr;
    end
  end

  always_comb begin
    curStride    = addrQ - rdLastAddr;
    predStride   = {{EXT_W{rdStride[STRIDE_W-1]}}, rdStride};
    strideHit    = (curStride == predStride);
    wrStrideData = strobes.writeStride ? curStride[STRIDE_W-1:0] : rdStride;
  end

  stride_table #(
    .IDX_W   (IDX_W),
    .ADDR_W  (ADDR_W),
    .STRIDE_W(STRIDE_W)
  ) u_table (
    .clk         (clk),
    .rst         (rst),
    .rdEn        (strobes.capture),
    .rdIdx       (rdIdx),
    .wrIdx       (idxQ),
    .wrAddrEn    (strobes.writeAddr),
    .wrAddrData  (addrQ),
    .wrStrideEn  (strobes.writeStride),
    .wrStrideData(wrStrideData),
    .rdLastAddr  (rdLastAddr),
    .rdStride    (rdStride)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      missValid <= 1'b0;
      missAddr  <= '0;
    end else begin
      missValid <= strobes.judge && !strideHit;
      if (strobes.judge && !strideHit) missAddr <= addrQ;
    end
  end

  trace_packer #(
    .BYTE_W(BYTE_W)
  ) u_packer (
    .clk      (clk),
    .rst      (rst),
    .bitValid (strobes.judge),
    .bitVal   (strideHit),
    .flush    (flush),
    .byteValid(traceValid),
    .byteData (traceByte),
    .byteFill (traceFill)
  );

  // R3: a miss record follows a failed comparison
  assert_miss_from_mismatch_R3: assert property (@(posedge clk) disable iff (rst)
    missValid |-> ($past(strobes.judge) && !$past(strideHit)));

  // R4: the operands of the stride rewrite are those that were judged
  assert_fixup_operands_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.writeStride |-> ($stable(addrQ) && $stable(rdLastAddr) && $stable(idxQ)));

endmodule

// File: rtl/stride_compressor.sv
module stride_compressor
  import stride_comp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 10,
  parameter int STRIDE_W = 8,
  parameter int BYTE_W   = 8,
  localparam int FILL_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [PC_W-1:0]   inPc,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              flush,
  output logic              traceValid,
  output logic [BYTE_W-1:0] traceByte,
  output logic [FILL_W-1:0] traceFill,
  output logic              missValid,
  output logic [ADDR_W-1:0] missAddr
);

  ctrlStrobes_t strobes;
  logic         strideHit;

  stride_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strideHit(strideHit),
    .inReady  (inReady),
    .strobes  (strobes)
  );

  stride_datapath #(
    .PC_W    (PC_W),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .STRIDE_W(STRIDE_W),
    .BYTE_W  (BYTE_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .inPc      (inPc),
    .inAddr    (inAddr),
    .flush     (flush),
    .strideHit (strideHit),
    .traceValid(traceValid),
    .traceByte (traceByte),
    .traceFill (traceFill),
    .missValid (missValid),
    .missAddr  (missAddr)
  );

endmodule

// File: tb/stride_compressor_test.sv
module stride_compressor_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 12;

  // {pc, address, expected outcome bit}
  localparam logic [64:0] VEC [NVEC] = '{
    {32'h0000_0100, 32'h0000_1000, 1'b0},  // R3 first touch, stride 0x1000
    {32'h0000_0100, 32'h0000_1004, 1'b0},  // R3 stride 4 learned
    {32'h0000_0100, 32'h0000_1008, 1'b1},  // R2
    {32'h0000_0100, 32'h0000_100C, 1'b1},  // R2
    {32'h0000_0204, 32'h0000_0000, 1'b1},  // R6 fresh entry reads 0/0
    {32'h0000_1100, 32'h0000_1010, 1'b1},  // R1 alias of pc 0x100
    {32'h0000_0100, 32'h0000_1008, 1'b0},  // R5 last is 0x1010, stride -8
    {32'h0000_0100, 32'h0000_1000, 1'b1},  // R4 negative stride matches
    {32'h0000_0100, 32'h0000_1100, 1'b0},  // R4 stride 0x100 truncates to 0
    {32'h0000_0100, 32'h0000_1100, 1'b1},  // R4 zero stride now matches
    {32'h0000_0100, 32'h0000_1200, 1'b0},  // R4 wide stride misses
    {32'h0000_0100, 32'h0000_1300, 1'b0}   // R4 and again
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inPc = '0;
  logic [31:0] inAddr = '0;
  logic        flush = 1'b0;
  logic        traceValid;
  logic [7:0]  traceByte;
  logic [3:0]  traceFill;
  logic        missValid;
  logic [31:0] missAddr;

  int nChecks = 0;
  int nFails  = 0;
  int missCnt = 0;
  int byteCnt = 0;
  logic [31:0] lastMiss = '0;
  logic [7:0]  lastByte = '0;
  logic [3:0]  lastFill = '0;
  bit finished = 1'b0;

  stride_compressor uut (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inReady   (inReady),
    .inPc      (inPc),
    .inAddr    (inAddr),
    .flush     (flush),
    .traceValid(traceValid),
    .traceByte (traceByte),
    .traceFill (traceFill),
    .missValid (missValid),
    .missAddr  (missAddr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (missValid) begin
        missCnt++;
        lastMiss = missAddr;
      end
      if (traceValid) begin
        byteCnt++;
        lastByte = traceByte;
        lastFill = traceFill;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] pc, input logic [31:0] a);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inPc    = pc;
    inAddr  = a;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendTimed(input logic [31:0] pc, input logic [31:0] a, output int stall);
    send(pc, a);
    stall = 0;
    while (!inReady) begin
      stall++;
      @(negedge clk);
    end
  endtask

  task automatic pulseFlush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int stall;
    int missBefore;
    int byteBefore;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: idle outputs after reset
    check(inReady == 1'b1, "R6 ready after reset", 32'(inReady), 32'd1);
    check(traceValid == 1'b0 && missValid == 1'b0, "R6 outputs idle",
          32'({traceValid, missValid}), 32'd0);

    // Vector table: one record, then a flush exposes its single outcome bit
    for (int i = 0; i < NVEC; i++) begin
      missBefore = missCnt;
      byteBefore = byteCnt;
      send(VEC[i][64:33], VEC[i][32:1]);
      repeat (2) @(negedge clk);
      pulseFlush();
      // R2/R3: outcome bit sits at bit 7 of a one-bit byte
      check(byteCnt == byteBefore + 1 && lastFill == 4'd1 && lastByte[7] == VEC[i][0]
            && lastByte[6:0] == 7'd0,
            $sformatf("R2 R3 vector %0d bit", i),
            {lastFill, 20'd0, lastByte}, {4'd1, 20'd0, VEC[i][0], 7'd0});
      if (VEC[i][0]) begin
        check(missCnt == missBefore, $sformatf("R2 vector %0d no miss", i),
              32'(missCnt - missBefore), 32'd0);
      end else begin
        check(missCnt == missBefore + 1 && lastMiss == VEC[i][32:1],
              $sformatf("R3 vector %0d miss address", i), lastMiss, VEC[i][32:1]);
      end
    end

    // R7 and R8: eight records at a fresh entry, one miss then seven hits
    byteBefore = byteCnt;
    for (int k = 0; k < 8; k++) begin
      sendTimed(32'h0000_0300, 32'(32'h40 * (k + 1)), stall);
      check(stall == ((k == 0) ? 2 : 1), $sformatf("R7 stall record %0d", k),
            32'(stall), ((k == 0) ? 32'd2 : 32'd1));
    end
    @(negedge clk);
    check(byteCnt == byteBefore + 1 && lastByte == 8'h7F && lastFill == 4'd8,
          "R8 full byte MSB first", {lastFill, 20'd0, lastByte}, {4'd8, 20'd0, 8'h7F});

    // R9: flush with nothing pending
    byteBefore = byteCnt;
    pulseFlush();
    check(byteCnt == byteBefore, "R9 empty flush emits nothing",
          32'(byteCnt - byteBefore), 32'd0);

    // R9: three bits 1,0,1 then flush -> 0xA0 with fill 3
    missBefore = missCnt;
    send(32'h0000_0300, 32'h0000_0240);
    send(32'h0000_0300, 32'h0000_0250);
    send(32'h0000_0300, 32'h0000_0260);
    repeat (3) @(negedge clk);
    pulseFlush();
    check(byteCnt == byteBefore + 1 && lastByte == 8'hA0 && lastFill == 4'd3,
          "R9 partial byte left aligned", {lastFill, 20'd0, lastByte}, {4'd3, 20'd0, 8'hA0});
    check(missCnt == missBefore + 1 && lastMiss == 32'h0000_0250,
          "R3 R5 single miss in run", lastMiss, 32'h0000_0250);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule